// File: doc/BRIEF.md
# External Bus Yield Controller

This block lets an outside master take over the processor's external memory bus. The outside master asks for the bus by pulling an active-low request line. The block watches the processor's own external accesses through a start/done handshake. It hands the bus over as soon as no access is in flight. Handing over means it disables the drivers for the address, data and strobe pins, pulls the active-low grant output, and stalls the core.

If an access is running when the request arrives, the handover waits until the cycle after that access ends. This can happen between two accesses of one instruction, because the instruction does not have to finish first. In go mode the core keeps running while the bus is lent out. It stalls only when it wants an external access. A separate active-low hung output tells the outside master that the core is ready to go but is blocked by the grant. The request is honoured even while the processor is held in reset.

When the request is released, the grant is withdrawn and the drivers are enabled again. The core then resumes, and any pending access may start.

Top module: `ext_bus_yield`

## Requirements
- R1: After reset the grant output `busGrantN` is high, `drvEn` is 1, `busGrantHungN` is high and no access is in progress.
- R2: `busReqN` is active low and passes through a two-stage synchronizer. With no access in flight, `busGrantN` goes low on the third rising clock edge after `busReqN` falls.
- R3: While the bus is granted, `drvEn` is 0 and `busGrantN` is 0. At all other times `drvEn` is 1 and `busGrantN` is 1.
- R4: An access counts as in progress from the edge after `accStart` until the edge at which `accDone` is sampled high. A request seen during an access is granted one cycle after that edge.
- R5: When an access ends while a synchronized request is pending, the grant takes priority over a new `accStart`. The bus can therefore be granted between two accesses of one instruction.
- R6: `accStart` is 0 while the bus is granted, while a synchronized request is active, while an access is in progress and while `procReset` is 1. Otherwise it equals `accReq`.
- R7: With `goMode` = 0, `coreStall` is 1 whenever the bus is granted.
- R8: With `goMode` = 1 and the bus granted, `coreStall` equals `accReq`.
- R9: `busGrantHungN` is 0 exactly when the bus is granted, `coreReady` is 1, the core is stalled by the grant, and `procReset` is 0.
- R10: On the third rising clock edge after `busReqN` rises, the grant is removed, drivers are re-enabled and the hung output goes high. In that same cycle a waiting `accReq` starts an access.
- R11: While `procReset` is 1, a request is still granted on the usual timing, `coreStall` is 1, and `accStart` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Active-low block reset |
| busReqN | input | 1 | Asynchronous active-low bus request from the outside master |
| goMode | input | 1 | 1 lets the core run while the bus is granted |
| procReset | input | 1 | 1 while the processor is held in reset |
| coreReady | input | 1 | Core has an instruction ready to execute |
| accReq | input | 1 | Core wants to start an external access |
| accDone | input | 1 | Access engine finishes the current access this cycle |
| accStart | output | 1 | Permission for the access engine to begin an access |
| drvEn | output | 1 | Output enable for the address, data and strobe drivers |
| busGrantN | output | 1 | Active-low bus grant |
| busGrantHungN | output | 1 | Active-low: core is blocked by the granted bus |
| coreStall | output | 1 | Holds the core pipeline |

## Verification
The embedded properties check, on every cycle, several invariants:
- A grant never coincides with an access in progress, and a grant never rises in the cycle after an access was still running.
- No access starts while the bus is granted.
- The grant tracks the synchronized request one cycle later.
- A hung indication implies both a grant and a stall.

Only the bench scenarios can show the exact latency counted from the raw pin. The same holds for:
- deferring the grant past a long access;
- choosing the grant over a second access of one instruction;
- the full stall and hung truth table across go mode, core readiness and access request;
- granting while the processor is in reset.

// File: rtl/bus_yield_pkg.sv
package bus_yield_pkg;
  // strobes from the control to the output stage
  typedef struct packed {
    logic grant;   // bus currently lent to the outside master
    logic inReset; // processor held in reset
  } yieldStb_t;
endpackage

// File: rtl/bus_req_sync.sv
module bus_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqN,
  output logic reqSync
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= 1'b0;
    else       chain[0] <= ~reqN;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[i] <= 1'b0;
      else       chain[i] <= chain[i-1];
    end
  end

  assign reqSync = chain[LAST];
endmodule

// File: rtl/bus_yield_ctrl.sv
module bus_yield_ctrl
  import bus_yield_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqSync,
  input  logic      accReq,
  input  logic      accDone,
  input  logic      procReset,
  output logic      accStart,
  output yieldStb_t stb
);
  logic grantQ;
  logic busyQ;

  // the request wins over a new access; nothing starts while lent out
  assign accStart = accReq && !grantQ && !reqSync && !busyQ && !procReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (busyQ) begin
      busyQ <= !accDone;
    end else begin
      busyQ <= accStart;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) grantQ <= 1'b0;
    else       grantQ <= reqSync && !busyQ;
  end

  assign stb.grant   = grantQ;
  assign stb.inReset = procReset;

  // R4: grant and an access in progress never overlap
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(grantQ && busyQ));

  // R4: a grant only rises after a cycle with no access in progress
  a_r4_grant_after_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantQ) |-> !$past(busyQ));

  // R6: no access begins while granted
  a_r6_no_start_granted: assert property (@(posedge clk) disable iff (!rstN)
    grantQ |-> !accStart);

  // R2: an idle synchronized request is granted one cycle later
  a_r2_grant_follows: assert property (@(posedge clk) disable iff (!rstN)
    (reqSync && !busyQ) |=> grantQ);

  // R10: a dropped request removes the grant one cycle later
  a_r10_release: assert property (@(posedge clk) disable iff (!rstN)
    !reqSync |=> !grantQ);
endmodule

// File: rtl/bus_yield_out.sv
module bus_yield_out
  import bus_yield_pkg::*;
(
  input  yieldStb_t stb,
  input  logic      goMode,
  input  logic      coreReady,
  input  logic      accReq,
  output logic      drvEn,
  output logic      busGrantN,
  output logic      busGrantHungN,
  output logic      coreStall
);
  logic grantStall;

  assign grantStall    = stb.grant && (!goMode || accReq);
  assign coreStall     = stb.inReset || grantStall;
  assign drvEn         = !stb.grant;
  assign busGrantN     = !stb.grant;
  assign busGrantHungN = !(grantStall && coreReady && !stb.inReset);
endmodule

// File: rtl/ext_bus_yield.sv
module ext_bus_yield
  import bus_yield_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReqN,
  input  logic goMode,
  input  logic procReset,
  input  logic coreReady,
  input  logic accReq,
  input  logic accDone,
  output logic accStart,
  output logic drvEn,
  output logic busGrantN,
  output logic busGrantHungN,
  output logic coreStall
);
  logic      reqSync;
  yieldStb_t stb;

  bus_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .reqN    (busReqN),
    .reqSync (reqSync)
  );

  bus_yield_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqSync   (reqSync),
    .accReq    (accReq),
    .accDone   (accDone),
    .procReset (procReset),
    .accStart  (accStart),
    .stb       (stb)
  );

  bus_yield_out u_out (
    .stb           (stb),
    .goMode        (goMode),
    .coreReady     (coreReady),
    .accReq        (accReq),
    .drvEn         (drvEn),
    .busGrantN     (busGrantN),
    .busGrantHungN (busGrantHungN),
    .coreStall     (coreStall)
  );

  // R9: a hung indication implies a grant and a stall
  a_r9_hung_implies: assert property (@(posedge clk) disable iff (!rstN)
    !busGrantHungN |-> (!busGrantN && coreStall));

  // R3: drivers are off exactly while granted
  a_r3_drv_grant: assert property (@(posedge clk) disable iff (!rstN)
    drvEn == busGrantN);

  // R6: no access may start while the outputs are released
  a_r6_start_drivers: assert property (@(posedge clk) disable iff (!rstN)
    accStart |-> drvEn);
endmodule

// File: tb/test_ext_bus_yield.sv
module test_ext_bus_yield;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReqN = 1'b1;
  logic goMode = 1'b0;
  logic procReset = 1'b0;
  logic coreReady = 1'b0;
  logic accReq = 1'b0;
  logic accDone = 1'b0;
  logic accStart, drvEn, busGrantN, busGrantHungN, coreStall;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_bus_yield i_ext_bus_yield (
    .clk(clk), .rstN(rstN), .busReqN(busReqN), .goMode(goMode),
    .procReset(procReset), .coreReady(coreReady), .accReq(accReq),
    .accDone(accDone), .accStart(accStart), .drvEn(drvEn),
    .busGrantN(busGrantN), .busGrantHungN(busGrantHungN),
    .coreStall(coreStall)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chkGranted(input string tag, input logic g);
    chk({tag, " busGrantN"}, busGrantN, !g);
    chk({tag, " drvEn"}, drvEn, !g);
  endtask

  // release the request and check the third-edge timing (R10)
  task automatic release3(input string tag);
    busReqN = 1'b1;
    step(); step();
    chkGranted({tag, " R10 still held"}, 1'b1);
    step();
    chkGranted({tag, " R10 released"}, 1'b0);
    chk({tag, " R10 hung high"}, busGrantHungN, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rstN = 1'b1;
    step();
    // R1 reset state
    chkGranted("R1", 1'b0);
    chk("R1 hung", busGrantHungN, 1'b1);
    chk("R1 stall", coreStall, 1'b0);
    accReq = 1'b1; #1;
    chk("R1 R6 start when idle", accStart, 1'b1);
    accReq = 1'b0; #1;

    // R2 / R3 latency from an idle bus
    busReqN = 1'b0;
    step(); step();
    chkGranted("R2 not yet", 1'b0);
    step();
    chkGranted("R2 R3 granted", 1'b1);

    // R6 R7 R8 R9 sweep while granted
    for (int v = 0; v < 8; v++) begin
      logic go, rdy, acc, expStall;
      go = v[2]; rdy = v[1]; acc = v[0];
      goMode = go; coreReady = rdy; accReq = acc;
      #1;
      expStall = !go || acc;
      chk(go ? "R8 stall" : "R7 stall", coreStall, expStall);
      chk("R9 hung", busGrantHungN, !(expStall && rdy));
      chk("R6 no start", accStart, 1'b0);
    end
    goMode = 1'b0; coreReady = 1'b1; accReq = 1'b1;
    release3("basic");
    chk("R10 start resumes", accStart, 1'b1);
    accReq = 1'b0; coreReady = 1'b0;
    step();

    // R4 request during a long access
    accReq = 1'b1; #1;
    chk("R4 start", accStart, 1'b1);
    step();
    accReq = 1'b0;
    busReqN = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step();
      chkGranted("R4 deferred", 1'b0);
    end
    accDone = 1'b1;
    step();
    accDone = 1'b0;
    chkGranted("R4 done edge", 1'b0);
    step();
    chkGranted("R4 granted after", 1'b1);
    release3("R4");

    // R5 grant between two accesses of one instruction
    accReq = 1'b1; #1;
    chk("R5 first start", accStart, 1'b1);
    step();
    chk("R6 busy no start", accStart, 1'b0);
    busReqN = 1'b0;
    step(); step();
    accDone = 1'b1;
    step();
    accDone = 1'b0;
    chk("R5 request wins", accStart, 1'b0);
    step();
    chkGranted("R5 granted between", 1'b1);
    coreReady = 1'b1; #1;
    chk("R9 hung between", busGrantHungN, 1'b0);
    release3("R5");
    chk("R5 second start", accStart, 1'b1);
    accReq = 1'b0; coreReady = 1'b0;
    step();

    // R11 grant while processor reset is active
    procReset = 1'b1; accReq = 1'b1; coreReady = 1'b1; #1;
    chk("R11 no start", accStart, 1'b0);
    chk("R11 stall", coreStall, 1'b1);
    busReqN = 1'b0;
    step(); step();
    chkGranted("R11 not yet", 1'b0);
    step();
    chkGranted("R11 granted", 1'b1);
    chk("R11 hung high", busGrantHungN, 1'b1);
    release3("R11");
    chk("R11 still no start", accStart, 1'b0);
    procReset = 1'b0; #1;
    chk("R11 start after reset", accStart, 1'b1);
    accReq = 1'b0; coreReady = 1'b0;
    step();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule